// File: doc/BRIEF.md
# Interrupt Queue Head/Tail Register Bank

This block keeps the head and tail offsets of four interrupt queues that share memory with software: one for cross-processor requests, one for device requests, one for resumable errors and one for non-resumable errors. Producers outside the block move a tail forward and software moves the head as it consumes entries. Both sides update the offsets through the write port of this block. The block compares each head with its tail and raises a pending line whenever the queue holds unconsumed entries.

Only three queues drive a line: the cross-processor queue, the device queue and the resumable error queue. The non-resumable error queue keeps its two offsets and reads them back like the others, but it never affects any output line. The write port carries separate head and tail strobes that share one queue select, so a single cycle can move both offsets of one queue. The read port is combinational and uses a 3-bit index.

Top module: `iq_regs`

## Requirements
- R1: Each of the eight 64-bit offset registers returns on `rd_data` the last value written to it. The read index encodes the queue in bits [2:1] (0 cross-processor, 1 device, 2 resumable error, 3 non-resumable error) and selects the head when bit 0 is 0 and the tail when bit 0 is 1.
- R2: `irq_cpu_mondo` is high exactly when the head and tail of queue 0 differ.
- R3: `irq_dev_mondo` is high exactly when the head and tail of queue 1 differ.
- R4: `irq_res_err` is high exactly when the head and tail of queue 2 differ.
- R5: Writes to queue 3 leave all three pending lines unchanged, whatever values the head and tail of queue 3 hold.
- R6: A write takes effect at the clock edge where `wr_head_en` or `wr_tail_en` is sampled high, and the matching pending line is re-evaluated in the same cycle. A pending line changes only after a write to its own queue.
- R7: When `wr_head_en` and `wr_tail_en` are both high, both offsets of the selected queue are updated in the same cycle. The pending line then reflects the two new values.
- R8: A synchronous active-high `rst` clears every offset to zero and drops every pending line.
- R9: A write changes only the registers of the queue selected by `wr_qsel`. The offsets of the other queues are not modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_qsel | input | 2 | Queue targeted by the write strobes |
| wr_head_en | input | 1 | Write `wr_head_data` into the selected head |
| wr_tail_en | input | 1 | Write `wr_tail_data` into the selected tail |
| wr_head_data | input | 64 | New head offset |
| wr_tail_data | input | 64 | New tail offset |
| rd_idx | input | 3 | Read index: queue in [2:1], tail when [0] is 1 |
| rd_data | output | 64 | Contents of the indexed register |
| irq_cpu_mondo | output | 1 | Cross-processor queue not empty |
| irq_dev_mondo | output | 1 | Device queue not empty |
| irq_res_err | output | 1 | Resumable error queue not empty |

## Verification
The hardest case to reach is a same-cycle write of head and tail in which each offset alone would flip the pending line but the pair together leaves it low. A separate case is a write that sets an offset equal to the value it already holds. The stimulus draws offsets from a pool of four values so that equal pairs come up often. The random phase also asserts both strobes in many cycles. A behavioural model of the eight offsets is compared against every pending line and one rotating readback on every clock.

// File: rtl/iq_pkg.sv
package iq_pkg;

    parameter int unsigned IQ_DATA_W = 64;
    parameter int unsigned IQ_NUM_Q  = 4;
    localparam int unsigned IQ_QSEL_W = $clog2(IQ_NUM_Q);
    localparam int unsigned IQ_IDX_W  = IQ_QSEL_W + 1;

    typedef enum logic [IQ_QSEL_W-1:0] {
        Q_CPU  = 2'd0,
        Q_DEV  = 2'd1,
        Q_RERR = 2'd2,
        Q_NERR = 2'd3
    } iq_queue_e;

    typedef struct packed {
        logic [IQ_DATA_W-1:0] head;
        logic [IQ_DATA_W-1:0] tail;
    } iq_pair_t;

    typedef struct packed {
        logic                 head_en;
        logic                 tail_en;
        logic [IQ_DATA_W-1:0] head_val;
        logic [IQ_DATA_W-1:0] tail_val;
    } iq_wr_t;

    function automatic logic iq_nonempty(iq_pair_t p);
        return p.head != p.tail;
    endfunction

    function automatic logic iq_has_line(int unsigned q);
        return q != int'(Q_NERR);
    endfunction

endpackage

// File: rtl/iq_ptr_pair.sv
module iq_ptr_pair
    import iq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  iq_wr_t   wr,
    output iq_pair_t pair
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pair <= '0;
        end else begin
            if (wr.head_en) pair.head <= wr.head_val;
            if (wr.tail_en) pair.tail <= wr.tail_val;
        end
    end

    assert_head_load_R1: assert property (@(posedge clk) disable iff (rst)
        wr.head_en |=> pair.head == $past(wr.head_val));

    assert_both_load_R7: assert property (@(posedge clk) disable iff (rst)
        (wr.head_en && wr.tail_en) |=>
            (pair.head == $past(wr.head_val) && pair.tail == $past(wr.tail_val)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr.head_en && !wr.tail_en) |=> $stable(pair));

endmodule

// File: rtl/iq_pend.sv
module iq_pend
    import iq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     touched,
    input  iq_pair_t pair,
    output logic     pend
);

    always_comb pend = iq_nonempty(pair);

    assert_pend_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !touched |=> $stable(pend));

    assert_pend_clear_R8: assert property (@(posedge clk)
        rst |=> !pend);

endmodule

// File: rtl/iq_regs.sv
module iq_regs
    import iq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IQ_QSEL_W-1:0] wr_qsel,
    input  logic                 wr_head_en,
    input  logic                 wr_tail_en,
    input  logic [IQ_DATA_W-1:0] wr_head_data,
    input  logic [IQ_DATA_W-1:0] wr_tail_data,
    input  logic [IQ_IDX_W-1:0]  rd_idx,
    output logic [IQ_DATA_W-1:0] rd_data,
    output logic                 irq_cpu_mondo,
    output logic                 irq_dev_mondo,
    output logic                 irq_res_err
);

    localparam int unsigned NLINE = IQ_NUM_Q - 1;

    iq_pair_t             pairs [IQ_NUM_Q];
    iq_wr_t               wrs   [IQ_NUM_Q];
    logic [NLINE-1:0]     lines;

    for (genvar q = 0; q < IQ_NUM_Q; q++) begin : g_q
        logic hit;
        always_comb begin
            hit             = (wr_qsel == IQ_QSEL_W'(q));
            wrs[q].head_en  = hit && wr_head_en;
            wrs[q].tail_en  = hit && wr_tail_en;
            wrs[q].head_val = wr_head_data;
            wrs[q].tail_val = wr_tail_data;
        end

        iq_ptr_pair u_pair (
            .clk  (clk),
            .rst  (rst),
            .wr   (wrs[q]),
            .pair (pairs[q])
        );

        if (iq_has_line(q)) begin : g_line
            iq_pend u_pend (
                .clk     (clk),
                .rst     (rst),
                .touched (wrs[q].head_en || wrs[q].tail_en),
                .pair    (pairs[q]),
                .pend    (lines[q])
            );
        end
    end

    always_comb begin
        if (rd_idx[0]) rd_data = pairs[rd_idx[IQ_IDX_W-1:1]].tail;
        else           rd_data = pairs[rd_idx[IQ_IDX_W-1:1]].head;
    end

    assign irq_cpu_mondo = lines[Q_CPU];
    assign irq_dev_mondo = lines[Q_DEV];
    assign irq_res_err   = lines[Q_RERR];

    assert_nerr_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_qsel == Q_NERR) |=> $stable({irq_cpu_mondo, irq_dev_mondo, irq_res_err}));

    assert_cpu_equal_pair_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_qsel == Q_CPU && wr_head_en && wr_tail_en && wr_head_data == wr_tail_data)
            |=> !irq_cpu_mondo);

    assert_dev_head_diff_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_qsel == Q_DEV && wr_head_en && wr_tail_en && wr_head_data != wr_tail_data)
            |=> irq_dev_mondo);

    assert_rerr_equal_pair_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_qsel == Q_RERR && wr_head_en && wr_tail_en && wr_head_data == wr_tail_data)
            |=> !irq_res_err);

    assert_reset_lines_R8: assert property (@(posedge clk)
        rst |=> (!irq_cpu_mondo && !irq_dev_mondo && !irq_res_err && rd_data == '0));

endmodule

// File: tb/test_iq_regs.sv
`timescale 1ns/1ps
module test_iq_regs;
    import iq_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [1:0]           wr_qsel = '0;
    logic                 wr_head_en = 1'b0;
    logic                 wr_tail_en = 1'b0;
    logic [63:0]          wr_head_data = '0;
    logic [63:0]          wr_tail_data = '0;
    logic [2:0]           rd_idx = '0;
    logic [63:0]          rd_data;
    logic                 irq_cpu_mondo, irq_dev_mondo, irq_res_err;

    int total = 0;
    int bad   = 0;
    string phase = "R8";

    // Behavioural reference: eight offsets
    logic [63:0] m_head [4];
    logic [63:0] m_tail [4];

    always #2.5 clk = ~clk;

    iq_regs i_iq_regs (
        .clk(clk), .rst(rst), .wr_qsel(wr_qsel),
        .wr_head_en(wr_head_en), .wr_tail_en(wr_tail_en),
        .wr_head_data(wr_head_data), .wr_tail_data(wr_tail_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .irq_cpu_mondo(irq_cpu_mondo), .irq_dev_mondo(irq_dev_mondo),
        .irq_res_err(irq_res_err)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < 4; q++) begin m_head[q] <= '0; m_tail[q] <= '0; end
        end else begin
            if (wr_head_en) m_head[wr_qsel] <= wr_head_data;
            if (wr_tail_en) m_tail[wr_qsel] <= wr_tail_data;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s) actual=%0h expected=%0h t=%0t", req, phase, act, exp, $time);
        end
    endtask

    // Compare at the falling edge, then drive the next cycle's inputs.
    task automatic step(input logic h, input logic t, input logic [1:0] q,
                        input logic [63:0] hv, input logic [63:0] tv);
        logic [63:0] exp_rd;
        @(negedge clk);
        chk("R2", {63'd0, irq_cpu_mondo}, {63'd0, m_head[0] != m_tail[0]});
        chk("R3", {63'd0, irq_dev_mondo}, {63'd0, m_head[1] != m_tail[1]});
        chk("R4", {63'd0, irq_res_err},   {63'd0, m_head[2] != m_tail[2]});
        exp_rd = rd_idx[0] ? m_tail[rd_idx[2:1]] : m_head[rd_idx[2:1]];
        chk("R1", rd_data, exp_rd);
        wr_head_en = h; wr_tail_en = t; wr_qsel = q;
        wr_head_data = hv; wr_tail_data = tv;
        rd_idx = rd_idx + 3'd1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, '0, '0);
    endtask

    initial begin : watchdog
        #(5ns * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [63:0] pool [4];
        logic [63:0] snap;
        pool[0] = 64'h0; pool[1] = 64'h40; pool[2] = 64'hFFFF_0000_0000_0080; pool[3] = 64'h40;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: everything zero after reset, sweep all eight registers
        phase = "R8";
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd_idx = 3'(i);
            #1 chk("R8", rd_data, 64'd0);
            chk("R8", {61'd0, irq_cpu_mondo, irq_dev_mondo, irq_res_err}, 64'd0);
        end
        // R2: cross-processor queue
        phase = "R2";
        step(1'b1, 1'b0, 2'd0, 64'h5, 0);
        step(1'b0, 1'b1, 2'd0, 0, 64'h5);
        step(1'b0, 1'b1, 2'd0, 0, 64'h9);
        idle(2);
        // R3: device queue
        phase = "R3";
        step(1'b0, 1'b1, 2'd1, 0, 64'h20);
        step(1'b1, 1'b0, 2'd1, 64'h20, 0);
        idle(2);
        // R4: resumable error queue
        phase = "R4";
        step(1'b1, 1'b0, 2'd2, 64'hDEAD_BEEF_0000_0001, 0);
        step(1'b0, 1'b1, 2'd2, 0, 64'hDEAD_BEEF_0000_0001);
        idle(2);
        // R5: non-resumable queue never raises a line
        phase = "R5";
        step(1'b1, 1'b0, 2'd3, 64'h77, 0);
        idle(1);
        @(negedge clk);
        chk("R5", {61'd0, irq_cpu_mondo, irq_dev_mondo, irq_res_err}, {61'd0, 1'b1, 1'b0, 1'b0});
        // R7: simultaneous writes, equal then unequal
        phase = "R7";
        step(1'b1, 1'b1, 2'd0, 64'hAB, 64'hAB);
        step(1'b1, 1'b1, 2'd1, 64'h3, 64'h4);
        idle(2);
        @(negedge clk);
        chk("R7", {62'd0, irq_cpu_mondo, irq_dev_mondo}, {62'd0, 1'b0, 1'b1});
        // R9/R6: a write to queue 2 leaves queue 1 offsets intact
        phase = "R9";
        snap = m_tail[1];
        step(1'b1, 1'b1, 2'd2, 64'h1, 64'h2);
        idle(1);
        @(negedge clk);
        rd_idx = 3'b011;
        #1 chk("R9", rd_data, snap);
        // R6: random traffic with frequent equal values
        phase = "R6";
        for (int i = 0; i < 600; i++) begin
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)),
                 pool[$urandom_range(0, 3)], pool[$urandom_range(0, 3)]);
        end
        idle(2);
        // R8: mid-run reset
        phase = "R8";
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #1 chk("R8", rd_data, 64'd0);
        end
        chk("R8", {61'd0, irq_cpu_mondo, irq_dev_mondo, irq_res_err}, 64'd0);
        idle(4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule